// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Frame Scan Sequencer

This block sequences the row scan of a 40-line, 1:40 multiplexed dot-matrix display from the display oscillator clock. It splits a fixed frame of 3072 oscillator cycles into 40 row slots. Ahead of each slot it fetches the bank that holds the coming line through a synchronous read port. It then picks that line's bit out of every column byte, applies the display mode, and presents a registered row index, a 101-bit column vector and a frame polarity bit to the analog drivers that follow.

A small command interface loads the two-bit display mode and the power-down flag. Reset leaves the block powered down. While it is powered down the scan is frozen and every output is held at its inactive value. The mode setting and the display RAM, which sits outside this block, keep their contents. Clearing power-down restarts the scan at line 0 of a fresh frame.

Top module: `lcd_scan_seq`

## Requirements
- R1: Rows 0 to 31 each stay on `row_idx` for 77 cycles and rows 32 to 39 each for 76 cycles, so one frame lasts 3072 cycles.
- R2: While scanning, `row_active` is 1 and `row_idx` steps 0, 1, ..., 39 and then wraps to 0.
- R3: `frame_pol` holds one value for a whole frame and inverts when row 0 of the next frame begins. The first frame after power-down is left has polarity 0.
- R4: In normal mode (mode code 2'b11), `col_data[c]` for line L is bit (L mod 8) of byte c of bank L/8. Byte c occupies `rd_data[8c+7:8c]`, and bit 0 is the top line of the bank.
- R5: Mode code 2'b00 gives all-zero columns, 2'b10 gives all-one columns and 2'b01 gives the inverse of normal. A mode write shows on `col_data` from the clock edge that accepts it.
- R6: One cycle after power-down is set, `row_active`, `row_idx`, `col_data` and `frame_pol` are all 0, `rd_en` is 0, and they stay so for as long as power-down is held. A mode write during power-down changes no output.
- R7: `rd_en` pulses for one cycle just before each row slot, with `rd_bank` set to the bank of the coming line. The data returned one cycle later forms that row's columns.
- R8: Reset sets `pd_out` to 1 with all scan outputs 0. Command writes in the first two cycles after reset is released are ignored.
- R9: After the command write that clears power-down, `row_active` rises at the third clock edge, showing row 0 with polarity 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_wr | input | 1 | Command write strobe |
| cmd_mode | input | 2 | Display mode code {E,D} |
| cmd_pd | input | 1 | Power-down flag to load |
| rd_en | output | 1 | Display RAM read request |
| rd_bank | output | BANK_W (3) | Bank to read |
| rd_data | input | NUM_COLS*BANK_BITS (808) | Bank contents, one byte per column, valid the cycle after `rd_en` |
| row_active | output | 1 | A row is being driven |
| row_idx | output | ROW_W (6) | Index of the driven row |
| col_data | output | NUM_COLS (101) | Column dot values for the driven row |
| frame_pol | output | 1 | Drive polarity of the current frame |
| pd_out | output | 1 | Power-down is in force |

## Verification
Two pairs of functions can meet in one cycle. A mode write can land on the frame wrap, where row 39 turns into row 0, the polarity inverts and a new column word is loaded. A power-down write can land on the last cycle of a frame. The bench counts cycles from the start of the scan and times its command writes by that count, so each event lands exactly on the boundary cycle. It then compares every output in every cycle against a row, polarity and column value worked out from the cycle index. After each power-down it checks that the outputs go inactive and that the scan restarts at row 0 with polarity 0.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
   // display mode code, bit 1 = E, bit 0 = D
   typedef enum logic [1:0] {
      MODE_BLANK   = 2'b00,
      MODE_INVERSE = 2'b01,
      MODE_ALL_ON  = 2'b10,
      MODE_NORMAL  = 2'b11
   } disp_mode_e;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
   import lcd_scan_pkg::*;
#(
   parameter int INIT_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cmd_wr,
   input  logic [1:0] cmd_mode,
   input  logic       cmd_pd,
   output logic       pd_q,
   output disp_mode_e mode_q
);
   localparam int INIT_W = $clog2(INIT_CYCLES + 1);

   logic [INIT_W-1:0] init_cnt;
   logic              ready;

   assign ready = (init_cnt == INIT_W'(INIT_CYCLES));

   always_ff @(posedge clk) begin
      if (rst) begin
         init_cnt <= '0;
         pd_q     <= 1'b1;
         mode_q   <= MODE_BLANK;
      end else if (!ready) begin
         init_cnt <= init_cnt + 1'b1;
      end else if (cmd_wr) begin
         pd_q   <= cmd_pd;
         mode_q <= disp_mode_e'(cmd_mode);
      end
   end

   assert_pd_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> pd_q);

   assert_cmd_ignored_in_init_R8: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && !ready) |=> (pd_q == $past(pd_q)) && (mode_q == $past(mode_q)));
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
   parameter int NUM_ROWS     = 40,
   parameter int FRAME_CYCLES = 3072,
   parameter int BANK_BITS    = 8,
   localparam int ROW_W       = $clog2(NUM_ROWS),
   localparam int NUM_BANKS   = NUM_ROWS / BANK_BITS,
   localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pd,
   output logic [ROW_W-1:0]  row_c,
   output logic              row_start,
   output logic              pol_c,
   output logic              live,
   output logic              rd_en,
   output logic [BANK_W-1:0] rd_bank
);
   localparam int BASE      = FRAME_CYCLES / NUM_ROWS;
   localparam int LONG_ROWS = FRAME_CYCLES % NUM_ROWS;
   localparam int CYC_W     = $clog2(BASE + 2);

   logic [CYC_W-1:0] cyc_c;
   logic [CYC_W-1:0] row_last;
   logic [ROW_W-1:0] nxt_row;
   logic             prime;
   logic             at_end;

   // the leading rows absorb the remainder of the frame split
   if (LONG_ROWS == 0) begin : g_even
      assign row_last = CYC_W'(BASE - 1);
   end else begin : g_uneven
      assign row_last = (row_c < ROW_W'(LONG_ROWS)) ? CYC_W'(BASE) : CYC_W'(BASE - 1);
   end

   assign at_end    = (cyc_c == row_last);
   assign nxt_row   = (row_c == ROW_W'(NUM_ROWS - 1)) ? '0 : row_c + 1'b1;
   assign live      = !pd && !prime;
   assign row_start = live && (cyc_c == '0);
   assign rd_en     = !pd && (prime || at_end);
   assign rd_bank   = prime ? '0 : BANK_W'(nxt_row / ROW_W'(BANK_BITS));

   always_ff @(posedge clk) begin
      if (rst || pd) begin
         row_c <= '0;
         cyc_c <= '0;
         pol_c <= 1'b0;
         prime <= 1'b1;
      end else if (prime) begin
         prime <= 1'b0;
      end else if (at_end) begin
         cyc_c <= '0;
         row_c <= nxt_row;
         if (row_c == ROW_W'(NUM_ROWS - 1)) pol_c <= ~pol_c;
      end else begin
         cyc_c <= cyc_c + 1'b1;
      end
   end

   assert_row_len_R1: assert property (@(posedge clk) disable iff (rst)
      cyc_c <= CYC_W'(BASE));

   assert_row_step_R2: assert property (@(posedge clk) disable iff (rst)
      (live && $past(live) && (row_c != $past(row_c))) |->
         ((row_c == $past(row_c) + 1'b1) ||
          (row_c == '0 && $past(row_c) == ROW_W'(NUM_ROWS - 1))));

   assert_pol_flip_at_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (live && $past(live) && (pol_c != $past(pol_c))) |->
         (row_c == '0 && $past(row_c) == ROW_W'(NUM_ROWS - 1)));

   assert_read_ahead_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !pd) |=> (pd || cyc_c == '0));

   assert_restart_row0_R9: assert property (@(posedge clk) disable iff (rst)
      (live && $past(prime) && !$past(pd)) |-> (row_c == '0 && !pol_c));
endmodule

// File: rtl/lcd_scan_colpath.sv
module lcd_scan_colpath
   import lcd_scan_pkg::*;
#(
   parameter int NUM_COLS  = 101,
   parameter int BANK_BITS = 8,
   parameter int ROW_W     = 6,
   localparam int SEL_W    = $clog2(BANK_BITS)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          live,
   input  logic                          row_start,
   input  logic [ROW_W-1:0]              row_c,
   input  logic                          pol_c,
   input  logic [NUM_COLS*BANK_BITS-1:0] rd_data,
   input  disp_mode_e                    mode,
   output logic                          row_active,
   output logic [ROW_W-1:0]              row_idx,
   output logic [NUM_COLS-1:0]           col_data,
   output logic                          frame_pol
);
   logic [SEL_W-1:0]    sel;
   logic [NUM_COLS-1:0] pick;
   logic [NUM_COLS-1:0] raw_q;
   logic [NUM_COLS-1:0] shaped;

   // line within the bank; bit 0 of each byte is the top line
   assign sel = SEL_W'(row_c % ROW_W'(BANK_BITS));

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      logic [BANK_BITS-1:0] col_byte;
      assign col_byte = rd_data[c*BANK_BITS +: BANK_BITS];
      assign pick[c]  = col_byte[sel];
   end

   always_ff @(posedge clk) begin
      if (rst || !live) begin
         row_active <= 1'b0;
         row_idx    <= '0;
         frame_pol  <= 1'b0;
         raw_q      <= '0;
      end else begin
         row_active <= 1'b1;
         row_idx    <= row_c;
         frame_pol  <= pol_c;
         if (row_start) raw_q <= pick;
      end
   end

   always_comb begin
      case (mode)
         MODE_NORMAL:  shaped = raw_q;
         MODE_INVERSE: shaped = ~raw_q;
         MODE_ALL_ON:  shaped = '1;
         default:      shaped = '0;
      endcase
      col_data = row_active ? shaped : '0;
   end
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
   import lcd_scan_pkg::*;
#(
   parameter int NUM_ROWS     = 40,
   parameter int NUM_COLS     = 101,
   parameter int FRAME_CYCLES = 3072,
   parameter int BANK_BITS    = 8,
   parameter int INIT_CYCLES  = 2,
   localparam int ROW_W       = $clog2(NUM_ROWS),
   localparam int NUM_BANKS   = NUM_ROWS / BANK_BITS,
   localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          cmd_wr,
   input  logic [1:0]                    cmd_mode,
   input  logic                          cmd_pd,
   output logic                          rd_en,
   output logic [BANK_W-1:0]             rd_bank,
   input  logic [NUM_COLS*BANK_BITS-1:0] rd_data,
   output logic                          row_active,
   output logic [ROW_W-1:0]              row_idx,
   output logic [NUM_COLS-1:0]           col_data,
   output logic                          frame_pol,
   output logic                          pd_out
);
   initial begin
      assert (NUM_ROWS % BANK_BITS == 0) else $error("rows must fill whole banks");
      assert (BANK_BITS >= 2) else $error("bank width too small");
      assert (FRAME_CYCLES >= 3 * NUM_ROWS) else $error("row slot too short");
      assert (INIT_CYCLES >= 1) else $error("init window must be positive");
   end

   logic             pd_q;
   disp_mode_e       mode_q;
   logic [ROW_W-1:0] row_c;
   logic             row_start;
   logic             pol_c;
   logic             live;

   lcd_scan_ctrl #(
      .INIT_CYCLES (INIT_CYCLES)
   ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .cmd_wr   (cmd_wr),
      .cmd_mode (cmd_mode),
      .cmd_pd   (cmd_pd),
      .pd_q     (pd_q),
      .mode_q   (mode_q)
   );

   lcd_scan_timer #(
      .NUM_ROWS     (NUM_ROWS),
      .FRAME_CYCLES (FRAME_CYCLES),
      .BANK_BITS    (BANK_BITS)
   ) u_timer (
      .clk       (clk),
      .rst       (rst),
      .pd        (pd_q),
      .row_c     (row_c),
      .row_start (row_start),
      .pol_c     (pol_c),
      .live      (live),
      .rd_en     (rd_en),
      .rd_bank   (rd_bank)
   );

   lcd_scan_colpath #(
      .NUM_COLS  (NUM_COLS),
      .BANK_BITS (BANK_BITS),
      .ROW_W     (ROW_W)
   ) u_colpath (
      .clk        (clk),
      .rst        (rst),
      .live       (live),
      .row_start  (row_start),
      .row_c      (row_c),
      .pol_c      (pol_c),
      .rd_data    (rd_data),
      .mode       (mode_q),
      .row_active (row_active),
      .row_idx    (row_idx),
      .col_data   (col_data),
      .frame_pol  (frame_pol)
   );

   assign pd_out = pd_q;

   assert_pd_outputs_off_R6: assert property (@(posedge clk) disable iff (rst)
      (pd_out && $past(pd_out)) |->
         (!row_active && col_data == '0 && !frame_pol && row_idx == '0 && !rd_en));
endmodule

// File: tb/lcd_scan_seq_bench.sv
module lcd_scan_seq_bench;
   localparam int ROWS  = 40;
   localparam int COLS  = 101;
   localparam int FRAME = 3072;
   localparam int BB    = 8;
   localparam int BASE  = FRAME / ROWS;
   localparam int LONGR = FRAME % ROWS;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              cmd_wr = 1'b0;
   logic [1:0]        cmd_mode = 2'b00;
   logic              cmd_pd = 1'b1;
   logic              rd_en;
   logic [2:0]        rd_bank;
   logic [COLS*BB-1:0] rd_data = '0;
   logic              row_active;
   logic [5:0]        row_idx;
   logic [COLS-1:0]   col_data;
   logic              frame_pol;
   logic              pd_out;

   int         n_cmp = 0;
   int         n_bad = 0;
   int         k = 0;
   logic       mon_en = 1'b0;
   logic       done = 1'b0;
   logic [1:0] exp_mode = 2'b00;

   always #4 clk = ~clk;

   lcd_scan_seq u_lcd_scan_seq (
      .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_mode(cmd_mode), .cmd_pd(cmd_pd),
      .rd_en(rd_en), .rd_bank(rd_bank), .rd_data(rd_data),
      .row_active(row_active), .row_idx(row_idx), .col_data(col_data),
      .frame_pol(frame_pol), .pd_out(pd_out)
   );

   function automatic logic [7:0] exp_byte(int b, int c);
      return 8'((b * 37 + c * 13 + 5) ^ (c >> 2));
   endfunction

   function automatic logic [COLS*BB-1:0] bank_word(int b);
      logic [COLS*BB-1:0] w;
      for (int c = 0; c < COLS; c++) w[c*BB +: BB] = exp_byte(b, c);
      return w;
   endfunction

   // synchronous RAM model, one cycle read latency
   always @(posedge clk) if (rd_en) rd_data <= bank_word(int'(rd_bank));

   function automatic int exp_row(int kk);
      int f = kk % FRAME;
      if (f < LONGR * (BASE + 1)) return f / (BASE + 1);
      return LONGR + (f - LONGR * (BASE + 1)) / BASE;
   endfunction

   function automatic logic [COLS-1:0] exp_col(int line, logic [1:0] m);
      logic [COLS-1:0] raw;
      for (int c = 0; c < COLS; c++) begin
         logic [7:0] bt = exp_byte(line / BB, c);
         raw[c] = bt[line % BB];
      end
      case (m)
         2'b11:   return raw;
         2'b01:   return ~raw;
         2'b10:   return '1;
         default: return '0;
      endcase
   endfunction

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at k=%0d: actual=%h expected=%h", tag, k, act, exp);
      end
   endtask

   task automatic chk_off(string tag);
      chk({tag, " row_active"}, 128'(row_active), 128'(0));
      chk({tag, " row_idx"}, 128'(row_idx), 128'(0));
      chk({tag, " col_data"}, 128'(col_data), 128'(0));
      chk({tag, " frame_pol"}, 128'(frame_pol), 128'(0));
      chk({tag, " rd_en"}, 128'(rd_en), 128'(0));
   endtask

   // per-cycle scan monitor
   always @(negedge clk) begin
      if (mon_en) begin
         int r;
         r = exp_row(k);
         chk("R2 row_active", 128'(row_active), 128'(1));
         chk("R1/R2 row_idx", 128'(row_idx), 128'(r));
         chk("R3 frame_pol", 128'(frame_pol), 128'((k / FRAME) % 2));
         chk("R4/R5 col_data", 128'(col_data), 128'(exp_col(r, exp_mode)));
         chk("R6 pd_out low", 128'(pd_out), 128'(0));
         k++;
      end
   end

   task automatic wcmd(logic [1:0] m, logic p);
      cmd_mode = m;
      cmd_pd   = p;
      cmd_wr   = 1'b1;
      @(posedge clk);
      #1;
      if (p) mon_en = 1'b0;
      else exp_mode = m;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   // clear power-down and start the monitor on the edge the scan appears
   task automatic leave_pd(logic [1:0] m);
      wcmd(m, 1'b0);
      chk("R9 not active after 1 edge", 128'(row_active), 128'(0));
      @(negedge clk);
      chk("R9 not active after 2 edges", 128'(row_active), 128'(0));
      chk("R7 read issued ahead of row 0", 128'(rd_en), 128'(0));
      @(posedge clk);
      #1;
      k = 0;
      mon_en = 1'b1;
   endtask

   task automatic enter_pd(logic [1:0] m);
      wcmd(m, 1'b1);
      chk("R6 pd_out set", 128'(pd_out), 128'(1));
      @(negedge clk);
      chk_off("R6 off");
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         chk_off("R6 held off");
      end
      // a mode write while powered down must leave outputs inactive
      wcmd(2'b10, 1'b1);
      for (int i = 0; i < 5; i++) begin
         chk_off("R6 mode write in power-down");
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset pd_out", 128'(pd_out), 128'(1));
      chk_off("R8 reset");
      rst = 1'b0;
      // writes during the two-cycle init window are dropped
      cmd_mode = 2'b11;
      cmd_pd   = 1'b0;
      cmd_wr   = 1'b1;
      repeat (2) @(negedge clk);
      cmd_wr = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R8 init write ignored pd_out", 128'(pd_out), 128'(1));
         chk("R8 init write ignored row_active", 128'(row_active), 128'(0));
      end

      leave_pd(2'b11);
      wait (k == FRAME - 1);
      wcmd(2'b01, 1'b0);                 // lands on the frame wrap
      wait (k == FRAME + BASE);
      wcmd(2'b00, 1'b0);                 // lands on a row change
      wait (k == FRAME + 300);
      wcmd(2'b10, 1'b0);
      wait (k == 2 * FRAME + LONGR * (BASE + 1) - 1);
      wcmd(2'b11, 1'b0);                 // first short row
      wait (k == 3 * FRAME - 1);
      wcmd(2'b01, 1'b0);
      wait (k == 3 * FRAME + 1000);
      enter_pd(2'b11);                   // mid-frame with polarity 1

      leave_pd(2'b11);
      wait (k == FRAME - 1);
      enter_pd(2'b11);                   // last cycle of a frame

      leave_pd(2'b10);
      wait (k == 200);
      wcmd(2'b11, 1'b0);
      wait (k == FRAME + 50);
      mon_en = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule